// File: doc/BRIEF.md
# PCI Configuration Header Register Subset

This block holds a few configuration-space registers of a single-function PCI target. It covers the cache line size, the latency timer, the header type and the I/O base address register. The bus interface decodes a configuration cycle and presents it to the block as a write strobe or a read strobe. Each strobe comes with a dword index, four byte enables and 32 bits of write data. Read data comes back combinationally from the same index. Every field is legalised as it is written. An unsupported cache line size collapses to zero. The fixed bits of the latency timer and of the base register cannot be changed, and the header type is a constant.

The block also decodes I/O accesses. During the address phase it compares the upper address bits with the stored base. When I/O decoding is enabled and the command is an I/O read or an I/O write, it raises a combinational hit. The bus interface registers that hit and uses it to claim the access in the next cycle.

Only the active-low hard reset clears the registers. The soft reset input is accepted so that the block can sit in both reset domains, but it leaves every register unchanged.

Top module: `pci_cfg_hdr_regs`

## Requirements
- R1: While the hard reset is active and right after it ends, dword index 3 reads 0x00000000 and dword index 4 reads 0x00000001.
- R2: A write to dword 3 with byte enable 0 set stores bits 7:0 as the cache line size when the value is 4, 8 or 16. Any other value makes bits 7:0 read 0.
- R3: The latency timer is read in bits 15:8 of dword 3. A write with byte enable 1 set stores write-data bits 15:10. Bits 9:8 always read 0.
- R4: Bits 31:16 of dword 3 always read 0. This covers the header type in bits 23:16, where 0 means a single-function device with the standard layout, and the unused byte above it. Writes to those bits have no effect.
- R5: A byte of dword 3 or dword 4 changes only when its byte enable is set during the write.
- R6: Dword 4 bits 31:5 hold the writable I/O base field. Bits 4:2 (the size field) and bit 1 read 0, and bit 0 reads 1 to mark an I/O BAR.
- R7: Pulsing the soft reset leaves every register unchanged.
- R8: io_hit is 1 exactly when io_en, ap_valid and a command of 4'b0010 (I/O read) or 4'b0011 (I/O write) are all present and ap_ad_hi equals the stored base field. It follows these inputs in the same cycle.
- R9: cfg_rdata is 0 when cfg_rd is low and when the dword index is neither 3 nor 4. A write to any other index changes nothing.
- R10: A hard reset applied after programming returns every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset; clears all registers |
| soft_rst | input | 1 | Soft reset; has no effect on these registers |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_rd | input | 1 | Configuration read strobe; enables cfg_rdata |
| cfg_dw_idx | input | 6 | Dword index inside configuration space |
| cfg_be | input | 4 | Byte enables, active high |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| io_en | input | 1 | I/O space decode enable from the command register |
| ap_valid | input | 1 | Address phase present |
| ap_cmd | input | 4 | Bus command of the address phase |
| ap_ad_hi | input | 27 | Address bits 31:5 of the address phase |
| io_hit | output | 1 | I/O access matches this device |

## Verification
The assertions assume that the bus interface never raises cfg_wr and soft_rst in the same cycle. They also assume that cfg_wr lasts one cycle per configuration write. The bench drives every strobe for exactly one clock and pulses the soft reset only while no write is pending. All inputs change on the falling edge, so the registered values the properties compare are never disturbed by stimulus that arrives at the sampling edge.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int unsigned DW_IDX_W      = 6;
    localparam int unsigned MISC_DW_IDX   = 3;
    localparam int unsigned IOBAR_DW_IDX  = 4;
    localparam int unsigned LT_FIXED_LSBS = 2;
    localparam int unsigned LT_WR_W       = 8 - LT_FIXED_LSBS;

    localparam logic [7:0] HDR_TYPE_VAL = 8'h00;
    localparam logic [3:0] CMD_IO_READ  = 4'b0010;
    localparam logic [3:0] CMD_IO_WRITE = 4'b0011;

    typedef struct packed {
        logic [7:0]         cls;
        logic [LT_WR_W-1:0] lt_hi;
    } misc_regs_t;

    function automatic logic cls_is_legal(input logic [7:0] v);
        return (v == 8'd4) || (v == 8'd8) || (v == 8'd16);
    endfunction

endpackage

// File: rtl/cfg_misc_dword.sv
module cfg_misc_dword
    import cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        hard_rst_n,
    input  logic        wr_en,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output logic [31:0] rdata
);

    misc_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && be[0]) begin
            regs_d.cls = cls_is_legal(wdata[7:0]) ? wdata[7:0] : 8'h00;
        end
        if (wr_en && be[1]) begin
            regs_d.lt_hi = wdata[15:8+LT_FIXED_LSBS];
        end
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = {8'h00, HDR_TYPE_VAL, regs_q.lt_hi,
                    {LT_FIXED_LSBS{1'b0}}, regs_q.cls};

    assert_cls_store_R2: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (wr_en && be[0] && cls_is_legal(wdata[7:0])) |=> (rdata[7:0] == $past(wdata[7:0])));

    assert_cls_clear_R2: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (wr_en && be[0] && !cls_is_legal(wdata[7:0])) |=> (rdata[7:0] == 8'h00));

    assert_lt_hold_R5: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !(wr_en && be[1]) |=> $stable(rdata[15:8]));

endmodule

// File: rtl/cfg_iobar.sv
module cfg_iobar
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned BASE_LSB = 5,
    localparam int unsigned BASE_W  = 32 - BASE_LSB
) (
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              wr_en,
    input  logic [3:0]        be,
    input  logic [BASE_W-1:0] wdata_hi,
    output logic [31:0]       rdata,
    input  logic              io_en,
    input  logic              ap_valid,
    input  logic [3:0]        ap_cmd,
    input  logic [BASE_W-1:0] ap_ad_hi,
    output logic              io_hit
);

    logic [BASE_W-1:0] base_d, base_q;
    logic              cmd_is_io;

    always_comb begin
        base_d = base_q;
        for (int i = BASE_LSB; i < 32; i++) begin
            if (wr_en && be[i/8]) begin
                base_d[i-BASE_LSB] = wdata_hi[i-BASE_LSB];
            end
        end
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign rdata     = {base_q, {(BASE_LSB-2){1'b0}}, 1'b0, 1'b1};
    assign cmd_is_io = (ap_cmd == CMD_IO_READ) || (ap_cmd == CMD_IO_WRITE);
    assign io_hit    = io_en && ap_valid && cmd_is_io && (ap_ad_hi == base_q);

    assert_hit_gated_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
        io_hit |-> (io_en && ap_valid && ap_cmd[3:1] == 3'b001));

    assert_base_hold_R6: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !wr_en |=> $stable(rdata));

endmodule

// File: rtl/pci_cfg_hdr_regs.sv
module pci_cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned BASE_LSB = 5,
    localparam int unsigned BASE_W  = 32 - BASE_LSB
) (
    input  logic                clk,
    input  logic                hard_rst_n,
    input  logic                soft_rst,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    input  logic [DW_IDX_W-1:0] cfg_dw_idx,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                io_en,
    input  logic                ap_valid,
    input  logic [3:0]          ap_cmd,
    input  logic [BASE_W-1:0]   ap_ad_hi,
    output logic                io_hit
);

    logic        sel_misc, sel_bar;
    logic [31:0] misc_rdata, bar_rdata;

    assign sel_misc = (cfg_dw_idx == DW_IDX_W'(MISC_DW_IDX));
    assign sel_bar  = (cfg_dw_idx == DW_IDX_W'(IOBAR_DW_IDX));

    cfg_misc_dword i_misc (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .wr_en      (cfg_wr && sel_misc),
        .be         (cfg_be[1:0]),
        .wdata      (cfg_wdata[15:0]),
        .rdata      (misc_rdata)
    );

    cfg_iobar #(.BASE_LSB(BASE_LSB)) i_iobar (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .wr_en      (cfg_wr && sel_bar),
        .be         (cfg_be),
        .wdata_hi   (cfg_wdata[31:BASE_LSB]),
        .rdata      (bar_rdata),
        .io_en      (io_en),
        .ap_valid   (ap_valid),
        .ap_cmd     (ap_cmd),
        .ap_ad_hi   (ap_ad_hi),
        .io_hit     (io_hit)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd && sel_misc) begin
            cfg_rdata = misc_rdata;
        end else if (cfg_rd && sel_bar) begin
            cfg_rdata = bar_rdata;
        end
    end

    assert_soft_keep_R7: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (soft_rst && !cfg_wr) |=> ($stable(misc_rdata) && $stable(bar_rdata)));

    assert_rd_gate_R9: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !cfg_rd |-> (cfg_rdata == 32'h0));

    assert_hdr_zero_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cfg_rd && sel_misc) |-> (cfg_rdata[31:16] == 16'h0));

endmodule

// File: tb/test_pci_cfg_hdr_regs.sv
module test_pci_cfg_hdr_regs;

    logic        clk = 1'b0;
    logic        hard_rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_en = 1'b0;
    logic        ap_valid = 1'b0;
    logic [3:0]  ap_cmd = '0;
    logic [26:0] ap_ad_hi = '0;
    logic        io_hit;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pci_cfg_hdr_regs i_pci_cfg_hdr_regs (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw_idx(cfg_dw_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_en(io_en), .ap_valid(ap_valid), .ap_cmd(ap_cmd),
        .ap_ad_hi(ap_ad_hi), .io_hit(io_hit)
    );

    // {dword index, byte enables, write data, expected read-back of same index}
    localparam int NV = 15;
    localparam logic [73:0] VEC [NV] = '{
        {6'd3, 4'b0001, 32'h0000_0004, 32'h0000_0004}, // R2 legal 4
        {6'd3, 4'b0001, 32'h0000_0008, 32'h0000_0008}, // R2 legal 8
        {6'd3, 4'b0001, 32'h0000_0010, 32'h0000_0010}, // R2 legal 16
        {6'd3, 4'b0001, 32'h0000_0005, 32'h0000_0000}, // R2 illegal
        {6'd3, 4'b0001, 32'h0000_0020, 32'h0000_0000}, // R2 illegal
        {6'd3, 4'b0001, 32'h0000_0008, 32'h0000_0008}, // R2
        {6'd3, 4'b0010, 32'h0000_FF00, 32'h0000_FC08}, // R3 low bits fixed
        {6'd3, 4'b0001, 32'h0000_0304, 32'h0000_FC04}, // R5 byte1 off
        {6'd3, 4'b1111, 32'hFFFF_4710, 32'h0000_4410}, // R4 header ignored
        {6'd4, 4'b1111, 32'hFFFF_FFFF, 32'hFFFF_FFE1}, // R6
        {6'd4, 4'b0011, 32'h0000_0000, 32'hFFFF_0001}, // R5 R6
        {6'd4, 4'b1100, 32'h1234_0000, 32'h1234_0001}, // R5
        {6'd5, 4'b1111, 32'hFFFF_FFFF, 32'h0000_0000}, // R9 other index
        {6'd3, 4'b0000, 32'hFFFF_FFFF, 32'h0000_4410}, // R5 no enables
        {6'd4, 4'b0001, 32'h0000_00A0, 32'h1234_00A1}  // R6 byte0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_idx = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic read_chk(input string req, input logic [5:0] idx, input logic [31:0] exp);
        cfg_rd = 1'b1; cfg_dw_idx = idx;
        #1;
        check(req, cfg_rdata, exp);
        cfg_rd = 1'b0;
    endtask

    task automatic hit_chk(input string req, input logic en, input logic v,
                           input logic [3:0] cmd, input logic [31:0] ad, input logic exp);
        io_en = en; ap_valid = v; ap_cmd = cmd; ap_ad_hi = ad[31:5];
        #1;
        check(req, {31'b0, io_hit}, {31'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        read_chk("R1", 6'd3, 32'h0000_0000);
        read_chk("R1", 6'd4, 32'h0000_0001);
        hard_rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1", 6'd3, 32'h0000_0000);
        read_chk("R1", 6'd4, 32'h0000_0001);

        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k][73:68], VEC[k][67:64], VEC[k][63:32]);
            read_chk("R2-vector", VEC[k][73:68], VEC[k][31:0]);
        end

        // R9: read strobe low gives zero
        cfg_dw_idx = 6'd4; cfg_rd = 1'b0; #1;
        check("R9", cfg_rdata, 32'h0);

        // R7: soft reset keeps contents
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        @(negedge clk);
        read_chk("R7", 6'd3, 32'h0000_4410);
        read_chk("R7", 6'd4, 32'h1234_00A1);

        // R8: I/O decode, base field = 0x123400A0 >> 5
        hit_chk("R8 io read",   1'b1, 1'b1, 4'b0010, 32'h1234_00BC, 1'b1);
        hit_chk("R8 io write",  1'b1, 1'b1, 4'b0011, 32'h1234_00A0, 1'b1);
        hit_chk("R8 mem cmd",   1'b1, 1'b1, 4'b0110, 32'h1234_00A0, 1'b0);
        hit_chk("R8 disabled",  1'b0, 1'b1, 4'b0010, 32'h1234_00A0, 1'b0);
        hit_chk("R8 mismatch",  1'b1, 1'b1, 4'b0010, 32'h1234_00C0, 1'b0);
        hit_chk("R8 no phase",  1'b1, 1'b0, 4'b0010, 32'h1234_00A0, 1'b0);
        hit_chk("R8 top bit",   1'b1, 1'b1, 4'b0011, 32'h9234_00A0, 1'b0);

        // R10: hard reset after programming
        @(negedge clk); hard_rst_n = 1'b0;
        @(negedge clk);
        read_chk("R10", 6'd3, 32'h0000_0000);
        read_chk("R10", 6'd4, 32'h0000_0001);
        hard_rst_n = 1'b1;
        @(negedge clk);
        hit_chk("R10 base cleared", 1'b1, 1'b1, 4'b0010, 32'h0000_0010, 1'b1);
        io_en = 1'b0; ap_valid = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule